// File: doc/BRIEF.md
# Multi-Sensor Thermal Threshold Monitor

This block watches one temperature reading per sensor, each in kelvin, and turns them into three requests for the rest of the chip: a soft throttle request, a forced throttle request and a shutdown request. Every sensor has its own warning, high and shutdown limit, loaded through a small write port that names a sensor and a field. Readings arrive one at a time as a valid-qualified sample tagged with a sensor index.

Each request is raised when any sensor is strictly hotter than its own limit for that level. The two throttle requests fall only once every sensor is strictly cooler than its limit. A reading equal to a limit neither raises nor lowers a request, which gives hysteresis at the exact threshold. The shutdown request is latched and only a reset clears it. Decisions are taken once per scan: after every sensor has delivered at least one sample since the previous decision.

Top module: `thermal_monitor`

## Requirements
- R1: While `rst` is high at a rising edge, all three requests go low on that edge and every limit and stored reading returns to 0.
- R2: After a scan decision, `throttleSoft` is 1 when at least one sensor's latest reading is strictly greater than its nonzero warning limit.
- R3: `throttleSoft` goes to 0 at a decision only when every sensor with a nonzero warning limit reads strictly below it; when no sensor is above and at least one reads exactly its limit, the request keeps its previous value.
- R4: `throttleForce` follows the rules of R2 and R3 against the high limits instead of the warning limits.
- R5: `shutdownReq` is set at a decision when at least one sensor reads strictly above its nonzero shutdown limit, and once set stays 1 however cool the readings become, until reset.
- R6: A limit of 0 marks that sensor as unused for that level: it never raises the request and never blocks its release.
- R7: A write with `cfgWr` high stores `cfgData` into the limit of sensor `cfgSensor` selected by `cfgField` (0 warning, 1 high, 2 shutdown); a write whose data is all ones (the value -1 in two's complement) or whose field code is 3 leaves every limit unchanged.
- R8: A scan completes on the rising edge that captures a sample making every sensor index seen since the last decision; the requests change only on the following rising edge, and never otherwise.
- R9: Samples and writes with a sensor index of `NUM_SENSORS` or more are ignored: they store nothing and do not count toward a scan.
- R10: The three levels are evaluated independently, so a reading can release the forced throttle while the soft throttle stays asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWr | input | 1 | Limit write strobe |
| cfgSensor | input | IDX_W | Sensor selected by the write |
| cfgField | input | 2 | Limit selected: 0 warning, 1 high, 2 shutdown, 3 none |
| cfgData | input | TEMP_W | Limit value in kelvin; all ones means keep |
| smpValid | input | 1 | Sample valid |
| smpSensor | input | IDX_W | Sensor the sample belongs to |
| smpTemp | input | TEMP_W | Reading in kelvin |
| throttleSoft | output | 1 | Soft throttle request (warning level) |
| throttleForce | output | 1 | Forced throttle request (high level) |
| shutdownReq | output | 1 | Latched shutdown request |

## Verification
The bench builds the block with three sensors and ten-bit temperatures. Three sensors on a two-bit index leave index 3 encodable but out of range, which makes the ignore rule for samples and writes observable, and the ten-bit width puts the keep code at 1023 while real kelvin values stay below it. Random scans pick readings at each limit and one kelvin either side, so the equality hold and the strict comparisons are hit often, alongside directed partial scans, unused sensors and the shutdown latch across cooling and reset.

// File: rtl/thermal_monitor_pkg.sv
package thermal_monitor_pkg;

  // Levels; the write field code equals the level index.
  localparam int NUM_LEVELS = 3;
  localparam int LVL_WARN   = 0;
  localparam int LVL_HIGH   = 1;
  localparam int LVL_SHUT   = 2;
  localparam logic [1:0] FLD_NONE = 2'd3;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;   // store smpTemp for smpSensor
    logic thrWrite;  // store cfgData into the selected limit
  } dpStrobe_t;

endpackage

// File: rtl/thermal_monitor_datapath.sv
module thermal_monitor_datapath
  import thermal_monitor_pkg::*;
#(
  parameter int NUM_SENSORS = 4,
  parameter int TEMP_W      = 10,
  parameter int IDX_W       = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  dpStrobe_t             dpStr,
  input  logic [IDX_W-1:0]      cfgSensor,
  input  logic [1:0]            cfgField,
  input  logic [TEMP_W-1:0]     cfgData,
  input  logic [IDX_W-1:0]      smpSensor,
  input  logic [TEMP_W-1:0]     smpTemp,
  output logic [NUM_LEVELS-1:0] anyAbove,
  output logic [NUM_LEVELS-1:0] allBelow
);

  logic [TEMP_W-1:0]      thrMem  [NUM_LEVELS][NUM_SENSORS];
  logic [TEMP_W-1:0]      reading [NUM_SENSORS];
  logic [NUM_SENSORS-1:0] aboveBits [NUM_LEVELS];
  logic [NUM_SENSORS-1:0] belowBits [NUM_LEVELS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SENSORS; s++) begin
        reading[s] <= '0;
        for (int lv = 0; lv < NUM_LEVELS; lv++) thrMem[lv][s] <= '0;
      end
    end else begin
      for (int s = 0; s < NUM_SENSORS; s++) begin
        if (dpStr.capture && smpSensor == IDX_W'(s)) reading[s] <= smpTemp;
        for (int lv = 0; lv < NUM_LEVELS; lv++) begin
          if (dpStr.thrWrite && cfgSensor == IDX_W'(s) && cfgField == 2'(lv))
            thrMem[lv][s] <= cfgData;
        end
      end
    end
  end

  // One comparator pair per sensor and level; a zero limit disables the pair.
  for (genvar lv = 0; lv < NUM_LEVELS; lv++) begin : g_level
    for (genvar s = 0; s < NUM_SENSORS; s++) begin : g_sensor
      logic inUse;
      assign inUse             = |thrMem[lv][s];
      assign aboveBits[lv][s]  = inUse && (reading[s] > thrMem[lv][s]);
      assign belowBits[lv][s]  = !inUse || (reading[s] < thrMem[lv][s]);
    end
    assign anyAbove[lv] = |aboveBits[lv];
    assign allBelow[lv] = &belowBits[lv];
  end

endmodule

// File: rtl/thermal_monitor_control.sv
module thermal_monitor_control
  import thermal_monitor_pkg::*;
#(
  parameter int NUM_SENSORS = 4,
  parameter int TEMP_W      = 10,
  parameter int IDX_W       = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfgWr,
  input  logic [IDX_W-1:0]      cfgSensor,
  input  logic [1:0]            cfgField,
  input  logic [TEMP_W-1:0]     cfgData,
  input  logic                  smpValid,
  input  logic [IDX_W-1:0]      smpSensor,
  input  logic [NUM_LEVELS-1:0] anyAbove,
  input  logic [NUM_LEVELS-1:0] allBelow,
  output dpStrobe_t             dpStr,
  output logic                  throttleSoft,
  output logic                  throttleForce,
  output logic                  shutdownReq
);

  localparam logic [IDX_W:0]         SENS_LIMIT = (IDX_W+1)'(NUM_SENSORS);
  localparam logic [NUM_SENSORS-1:0] ALL_SEEN   = '1;

  logic                   sampleOk, cfgOk, scanFull, evalPending;
  logic [NUM_SENSORS-1:0] seen, seenNext;
  logic [NUM_LEVELS-1:0]  lvlState;
  logic                   unusedShutBelow;

  assign sampleOk = smpValid && ({1'b0, smpSensor} < SENS_LIMIT);
  assign cfgOk    = cfgWr && ({1'b0, cfgSensor} < SENS_LIMIT)
                    && (cfgField != FLD_NONE) && (cfgData != '1);

  always_comb begin
    dpStr          = '0;
    dpStr.capture  = sampleOk;
    dpStr.thrWrite = cfgOk;
  end

  always_comb begin
    for (int s = 0; s < NUM_SENSORS; s++)
      seenNext[s] = seen[s] | (sampleOk && smpSensor == IDX_W'(s));
  end

  assign scanFull = sampleOk && (seenNext == ALL_SEEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      seen        <= '0;
      evalPending <= 1'b0;
    end else begin
      evalPending <= scanFull;
      seen        <= scanFull ? '0 : seenNext;
    end
  end

  // Per-level decision: hysteresis for throttles, sticky latch for shutdown.
  for (genvar lv = 0; lv < NUM_LEVELS; lv++) begin : g_decide
    if (lv == LVL_SHUT) begin : g_sticky
      always_ff @(posedge clk) begin
        if (rst)                                lvlState[lv] <= 1'b0;
        else if (evalPending && anyAbove[lv])   lvlState[lv] <= 1'b1;
      end
    end else begin : g_hyst
      always_ff @(posedge clk) begin
        if (rst)                    lvlState[lv] <= 1'b0;
        else if (evalPending) begin
          if (anyAbove[lv])         lvlState[lv] <= 1'b1;
          else if (allBelow[lv])    lvlState[lv] <= 1'b0;
        end
      end
    end
  end

  assign unusedShutBelow = allBelow[LVL_SHUT];

  assign throttleSoft  = lvlState[LVL_WARN];
  assign throttleForce = lvlState[LVL_HIGH];
  assign shutdownReq   = lvlState[LVL_SHUT];

endmodule

// File: rtl/thermal_monitor.sv
module thermal_monitor
  import thermal_monitor_pkg::*;
#(
  parameter int NUM_SENSORS = 4,
  parameter int TEMP_W      = 10,
  parameter int IDX_W       = (NUM_SENSORS > 1) ? $clog2(NUM_SENSORS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWr,
  input  logic [IDX_W-1:0]  cfgSensor,
  input  logic [1:0]        cfgField,
  input  logic [TEMP_W-1:0] cfgData,
  input  logic              smpValid,
  input  logic [IDX_W-1:0]  smpSensor,
  input  logic [TEMP_W-1:0] smpTemp,
  output logic              throttleSoft,
  output logic              throttleForce,
  output logic              shutdownReq
);

  dpStrobe_t             dpStr;
  logic [NUM_LEVELS-1:0] anyAbove, allBelow;

  thermal_monitor_control #(
    .NUM_SENSORS(NUM_SENSORS), .TEMP_W(TEMP_W), .IDX_W(IDX_W)
  ) u_control (
    .clk(clk), .rst(rst),
    .cfgWr(cfgWr), .cfgSensor(cfgSensor), .cfgField(cfgField), .cfgData(cfgData),
    .smpValid(smpValid), .smpSensor(smpSensor),
    .anyAbove(anyAbove), .allBelow(allBelow),
    .dpStr(dpStr),
    .throttleSoft(throttleSoft), .throttleForce(throttleForce), .shutdownReq(shutdownReq)
  );

  thermal_monitor_datapath #(
    .NUM_SENSORS(NUM_SENSORS), .TEMP_W(TEMP_W), .IDX_W(IDX_W)
  ) u_datapath (
    .clk(clk), .rst(rst), .dpStr(dpStr),
    .cfgSensor(cfgSensor), .cfgField(cfgField), .cfgData(cfgData),
    .smpSensor(smpSensor), .smpTemp(smpTemp),
    .anyAbove(anyAbove), .allBelow(allBelow)
  );

endmodule

// File: rtl/thermal_monitor_checker.sv
module thermal_monitor_checker #(
  parameter int NUM_SENSORS = 4,
  parameter int IDX_W       = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             smpValid,
  input logic [IDX_W-1:0] smpSensor,
  input logic             throttleSoft,
  input logic             throttleForce,
  input logic             shutdownReq
);

  // Independent scan tracker built from the sample port alone.
  logic [NUM_SENSORS-1:0] seenChk, seenChkNext;
  logic                   evalChk, rstQ;

  always_comb begin
    for (int s = 0; s < NUM_SENSORS; s++)
      seenChkNext[s] = seenChk[s] | (smpValid && ({1'b0, smpSensor} == (IDX_W+1)'(s)));
  end

  always_ff @(posedge clk) begin
    rstQ <= rst;
    if (rst) begin
      seenChk <= '0;
      evalChk <= 1'b0;
    end else if (&seenChkNext) begin
      seenChk <= '0;
      evalChk <= 1'b1;
    end else begin
      seenChk <= seenChkNext;
      evalChk <= 1'b0;
    end
  end

  // R1: the cycle after a reset edge, every request is low.
  always @(negedge clk) begin
    if (rstQ === 1'b1)
      p_reset_low_r1: assert (!throttleSoft && !throttleForce && !shutdownReq);
  end

  // R5: shutdown never falls outside reset.
  p_shut_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    shutdownReq |=> shutdownReq);

  // R8: requests hold unless a scan completed on the previous edge.
  p_hold_between_scans_r8: assert property (@(posedge clk) disable iff (rst)
    !evalChk |=> $stable({throttleSoft, throttleForce, shutdownReq}));

  // R2: a soft request only rises on a decision edge.
  p_soft_rise_on_scan_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(throttleSoft) |-> $past(evalChk));

  // R4: a forced request only rises on a decision edge.
  p_force_rise_on_scan_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(throttleForce) |-> $past(evalChk));

endmodule

bind thermal_monitor thermal_monitor_checker #(
  .NUM_SENSORS(NUM_SENSORS), .IDX_W(IDX_W)
) u_checker (
  .clk(clk), .rst(rst), .smpValid(smpValid), .smpSensor(smpSensor),
  .throttleSoft(throttleSoft), .throttleForce(throttleForce), .shutdownReq(shutdownReq)
);

// File: tb/test_thermal_monitor.sv
module test_thermal_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int N     = 3;
  localparam int TW    = 10;
  localparam int IW    = 2;
  localparam int KEEP  = (1 << TW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfgWr = 1'b0;
  logic [IW-1:0] cfgSensor = '0;
  logic [1:0]    cfgField = '0;
  logic [TW-1:0] cfgData = '0;
  logic          smpValid = 1'b0;
  logic [IW-1:0] smpSensor = '0;
  logic [TW-1:0] smpTemp = '0;
  logic          throttleSoft, throttleForce, shutdownReq;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // Model state
  int mThr [3][N];
  int mTemp [N];
  bit mSeen [N];
  bit mPend;
  bit mOut [3];

  thermal_monitor #(.NUM_SENSORS(N), .TEMP_W(TW)) i_thermal_monitor (
    .clk(clk), .rst(rst), .cfgWr(cfgWr), .cfgSensor(cfgSensor), .cfgField(cfgField),
    .cfgData(cfgData), .smpValid(smpValid), .smpSensor(smpSensor), .smpTemp(smpTemp),
    .throttleSoft(throttleSoft), .throttleForce(throttleForce), .shutdownReq(shutdownReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void modelReset();
    for (int s = 0; s < N; s++) begin
      mTemp[s] = 0; mSeen[s] = 0;
      for (int lv = 0; lv < 3; lv++) mThr[lv][s] = 0;
    end
    mPend = 0;
    for (int lv = 0; lv < 3; lv++) mOut[lv] = 0;
  endfunction

  function automatic void modelDecide();
    for (int lv = 0; lv < 3; lv++) begin
      bit anyA = 0;
      bit allB = 1;
      for (int s = 0; s < N; s++) begin
        if (mThr[lv][s] != 0) begin
          if (mTemp[s] > mThr[lv][s]) anyA = 1;
          if (!(mTemp[s] < mThr[lv][s])) allB = 0;
        end
      end
      if (anyA) mOut[lv] = 1;
      else if (allB && lv != 2) mOut[lv] = 0;
    end
  endfunction

  // One clock: model follows the edge, then outputs are compared (R8 timing).
  task automatic step();
    @(posedge clk);
    if (rst) modelReset();
    else begin
      if (mPend) modelDecide();
      mPend = 0;
      if (cfgWr && int'(cfgSensor) < N && cfgField != 2'd3 && int'(cfgData) != KEEP)
        mThr[cfgField][cfgSensor] = int'(cfgData);
      if (smpValid && int'(smpSensor) < N) begin
        bit all = 1;
        mTemp[smpSensor] = int'(smpTemp);
        mSeen[smpSensor] = 1;
        for (int s = 0; s < N; s++) all &= mSeen[s];
        if (all) begin
          mPend = 1;
          for (int s = 0; s < N; s++) mSeen[s] = 0;
        end
      end
    end
    #1;
    cfgWr = 0; smpValid = 0;
    chk("R8 soft per-cycle", throttleSoft, mOut[0]);
    chk("R8 force per-cycle", throttleForce, mOut[1]);
    chk("R8 shutdown per-cycle", shutdownReq, mOut[2]);
  endtask

  task automatic idle(); step(); endtask

  task automatic sample(int s, int t);
    smpValid = 1; smpSensor = IW'(s); smpTemp = TW'(t);
    step();
  endtask

  task automatic writeThr(int s, int f, int v);
    cfgWr = 1; cfgSensor = IW'(s); cfgField = 2'(f); cfgData = TW'(v);
    step();
  endtask

  task automatic scan(int a, int b, int c);
    sample(0, a); sample(1, b); sample(2, c); idle();
  endtask

  task automatic expectOut(string tag, int s, int f, int d);
    chk({tag, " soft"}, throttleSoft, s);
    chk({tag, " force"}, throttleForce, f);
    chk({tag, " shutdown"}, shutdownReq, d);
  endtask

  task automatic doReset();
    rst = 1; step(); step(); rst = 0;
  endtask

  function automatic int nearTemp(int s);
    int lv = int'($urandom_range(0, 2));
    int t;
    if ($urandom_range(0, 4) == 0) return int'($urandom_range(250, 450));
    t = mThr[lv][s] + int'($urandom_range(0, 2)) - 1;
    if (t < 0) t = 0;
    if (t > KEEP) t = KEEP;
    return t;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    modelReset();
    #1;
    doReset();
    expectOut("R1 after reset", 0, 0, 0);

    // R6: all limits zero, hot readings raise nothing
    scan(900, 900, 900);
    expectOut("R6 all unused", 0, 0, 0);

    writeThr(0, 0, 373); writeThr(0, 1, 387); writeThr(0, 2, 400);
    writeThr(1, 0, 350); writeThr(1, 1, 360); writeThr(1, 2, 420);
    // R7: keep code and field 3 leave the warning limit at 373
    writeThr(0, 0, KEEP);
    writeThr(0, 3, 100);
    scan(380, 300, 1000);
    expectOut("R7 keep write / R2 any above", 1, 0, 0);
    scan(373, 300, 1000);
    expectOut("R3 equal holds high", 1, 0, 0);
    scan(372, 300, 1000);
    expectOut("R3 all below releases / R6 unused no block", 0, 0, 0);
    scan(373, 350, 5);
    expectOut("R3 equal holds low", 0, 0, 0);
    scan(300, 351, 0);
    expectOut("R2 second sensor above", 1, 0, 0);
    scan(390, 300, 0);
    expectOut("R4 high above", 1, 1, 0);
    scan(387, 300, 0);
    expectOut("R4 high equal holds", 1, 1, 0);
    scan(380, 300, 0);
    expectOut("R10 force released soft kept", 1, 0, 0);

    // R8: partial scan changes nothing; R9: out-of-range sample ignored
    sample(0, 200); sample(1, 200); idle(); idle();
    expectOut("R8 partial scan", 1, 0, 0);
    sample(3, 900); idle();
    expectOut("R9 index out of range", 1, 0, 0);
    writeThr(3, 0, 1);
    sample(2, 0); idle();
    expectOut("R8 scan completes on last sensor", 0, 0, 0);

    scan(401, 300, 0);
    expectOut("R5 shutdown set", 1, 1, 1);
    scan(200, 200, 0);
    expectOut("R5 shutdown sticky when cool", 0, 0, 1);
    doReset();
    expectOut("R1 reset clears latch", 0, 0, 0);

    // Random phase, checked every cycle against the model
    for (int it = 0; it < 600; it++) begin
      int r = int'($urandom_range(0, 99));
      if (r < 2) doReset();
      else if (r < 25)
        writeThr(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                 ($urandom_range(0, 7) == 0) ? KEEP :
                 ($urandom_range(0, 7) == 0) ? 0 : int'($urandom_range(300, 420)));
      else begin
        for (int s = 0; s < N; s++) begin
          if ($urandom_range(0, 9) == 0) sample(3, 999);
          if ($urandom_range(0, 9) == 0) idle();
          sample(s, nearTemp(s));
        end
        idle();
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule